// File: doc/BRIEF.md
# Sprite Line Buffer Pair

This block holds the sprite pixels of two scanlines. While the sprite renderer fills one buffer with the pixels of the coming line, the display side reads the other buffer one pixel per clock, and every location it reads is cleared in the same cycle. A line-start strobe swaps the two roles. The next line's renderer therefore always begins on a buffer that the display has just emptied.

Erasure happens only when a pixel is actually shown. When the display is turned off, renderer writes are dropped, the display side outputs transparent pixels, and the display buffer is left untouched. The same applies to the leftmost column when the left-column blank is set. Old sprite pixels can therefore survive in a buffer and come back on a later line. That behaviour is part of the function.

Each entry holds a pixel code, and the value zero means transparent. The depth covers the widest display mode. A mode input selects a narrow or a wide active width, and renderer writes at or beyond that width are dropped.

Top module: `sprite_linebuf`

## Requirements
- R1: After reset, `pix_out` is 0 and every entry of both buffers reads as 0.
- R2: Each rising `line_start` swaps the render and display buffers, whatever the state of `disp_en`. After reset, buffer A renders and buffer B is displayed. Pixels written during a line can be read only after the next swap.
- R3: When `rd_en` is high in a cycle, `pix_out` shows the display-buffer entry at `rd_x` after the next clock edge. In a cycle with `rd_en` low, `pix_out` becomes 0 after that edge.
- R4: A displayed read clears the entry it reads in the same cycle. A second read of that location before it is rewritten returns 0.
- R5: The renderer can store one pixel on every clock. Writes on back-to-back cycles are all kept.
- R6: While `disp_en` is 0, renderer writes are dropped and reads output 0 without clearing anything. Entries that are never shown keep their contents through any number of swaps.
- R7: While `left_blank` is 1, writes and reads at `x` < 8 behave as under R6. Positions 8 and above work normally.
- R8: With `wide_mode` = 1 the active width is 320, and with `wide_mode` = 0 it is 256. Writes at `x` at or beyond the active width are dropped. Reads at `x` >= 320 output 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | Line boundary strobe, swaps buffer roles |
| disp_en | input | 1 | Display enable |
| left_blank | input | 1 | Blank the leftmost 8 columns |
| wide_mode | input | 1 | 1: 320-pixel width, 0: 256-pixel width |
| wr_en | input | 1 | Renderer write strobe |
| wr_x | input | 9 | Renderer write column |
| wr_pix | input | 6 | Renderer pixel code (0 = transparent) |
| rd_en | input | 1 | Display scan strobe |
| rd_x | input | 9 | Display read column |
| pix_out | output | 6 | Displayed sprite pixel, one cycle after the read |

## Verification
The hardest situation to reach is stale data: pixels sitting in a buffer that was never scanned out, which then show up on a later line. Only a long sequence of swaps, with blanking or left-column blanking set during the reads, reaches this state. The stimulus writes a marker, swaps without reading it or with reads suppressed, swaps further, and then reads it back with display enabled. It also writes a left-column pixel while the column is open and hides it during one scan, so that it shows up on a later scan. In the same way, a write made under blanking is shown to be absent by reading its location after a swap.

// File: rtl/spr_lb_pkg.sv
package spr_lb_pkg;
  typedef enum logic {
    BANK_A = 1'b0,
    BANK_B = 1'b1
  } bank_e;
endpackage

// File: rtl/lb_swap.sv
module lb_swap
  import spr_lb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  line_start,
  output bank_e render_sel
);
  bank_e sel_q;
  bank_e sel_d;

  always_comb begin
    sel_d = sel_q;
    if (line_start) sel_d = bank_e'(~sel_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= BANK_A;
    else        sel_q <= sel_d;
  end

  assign render_sel = sel_q;

  // R2: roles swap on every line strobe, and only then
  assert_swap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> sel_q != $past(sel_q));
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |=> $stable(sel_q));
endmodule

// File: rtl/lb_gate.sv
module lb_gate #(
  parameter int AW        = 9,
  parameter int DEPTH     = 320,
  parameter int NARROW_W  = 256,
  parameter int WIDE_W    = 320,
  parameter int LEFT_COLS = 8
) (
  input  logic          disp_en,
  input  logic          left_blank,
  input  logic          wide_mode,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_x,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_x,
  output logic          wr_go,
  output logic          rd_go
);
  localparam logic [AW:0] LIM_NARROW = (AW+1)'(NARROW_W);
  localparam logic [AW:0] LIM_WIDE   = (AW+1)'(WIDE_W);
  localparam logic [AW:0] LIM_DEPTH  = (AW+1)'(DEPTH);
  localparam logic [AW:0] LIM_LEFT   = (AW+1)'(LEFT_COLS);

  logic [AW:0] act_w;
  logic        wr_in_w, wr_left, rd_in_d, rd_left;

  always_comb begin
    act_w   = wide_mode ? LIM_WIDE : LIM_NARROW;
    wr_in_w = {1'b0, wr_x} < act_w;
    wr_left = {1'b0, wr_x} < LIM_LEFT;
    rd_in_d = {1'b0, rd_x} < LIM_DEPTH;
    rd_left = {1'b0, rd_x} < LIM_LEFT;
    wr_go   = wr_en & disp_en & wr_in_w & ~(left_blank & wr_left);
    rd_go   = rd_en & disp_en & rd_in_d & ~(left_blank & rd_left);
  end
endmodule

// File: rtl/lb_bank.sv
module lb_bank #(
  parameter int AW    = 9,
  parameter int DEPTH = 320,
  parameter int PW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [PW-1:0] wdata,
  input  logic          clr,
  input  logic [AW-1:0] raddr,
  output logic [PW-1:0] rdata
);
  localparam logic [AW-1:0] TOP_ADDR = AW'(DEPTH);

  logic [PW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (we)  mem[waddr] <= wdata;
      if (clr) mem[raddr] <= '0;
    end
  end

  assign rdata = (raddr < TOP_ADDR) ? mem[raddr] : '0;

  // R2: a bank is either rendering or displaying, never both at once
  assert_no_clash_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && clr));
  // R8: no write lands outside the storage
  assert_wr_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> waddr < TOP_ADDR);
endmodule

// File: rtl/sprite_linebuf.sv
module sprite_linebuf
  import spr_lb_pkg::*;
#(
  parameter int PW        = 6,
  parameter int DEPTH     = 320,
  parameter int NARROW_W  = 256,
  parameter int LEFT_COLS = 8,
  localparam int AW       = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_start,
  input  logic          disp_en,
  input  logic          left_blank,
  input  logic          wide_mode,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_x,
  input  logic [PW-1:0] wr_pix,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_x,
  output logic [PW-1:0] pix_out
);
  localparam int NBANK = 2;
  localparam logic [AW-1:0] LEFT_X = AW'(LEFT_COLS);

  bank_e render_sel;
  logic  wr_go, rd_go;
  logic [NBANK-1:0]         bank_we, bank_clr;
  logic [NBANK-1:0][PW-1:0] bank_rd;
  logic [PW-1:0]            disp_data;
  logic [PW-1:0]            pix_d, pix_q;

  lb_swap u_swap (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_start (line_start),
    .render_sel (render_sel)
  );

  lb_gate #(
    .AW(AW), .DEPTH(DEPTH), .NARROW_W(NARROW_W),
    .WIDE_W(DEPTH), .LEFT_COLS(LEFT_COLS)
  ) u_gate (
    .disp_en    (disp_en),
    .left_blank (left_blank),
    .wide_mode  (wide_mode),
    .wr_en      (wr_en),
    .wr_x       (wr_x),
    .rd_en      (rd_en),
    .rd_x       (rd_x),
    .wr_go      (wr_go),
    .rd_go      (rd_go)
  );

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    assign bank_we[g]  = wr_go & (render_sel == bank_e'(g));
    assign bank_clr[g] = rd_go & (render_sel != bank_e'(g));
    lb_bank #(.AW(AW), .DEPTH(DEPTH), .PW(PW)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (bank_we[g]),
      .waddr (wr_x),
      .wdata (wr_pix),
      .clr   (bank_clr[g]),
      .raddr (rd_x),
      .rdata (bank_rd[g])
    );
  end

  always_comb begin
    disp_data = bank_rd[~render_sel];
    pix_d     = rd_go ? disp_data : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pix_q <= '0;
    else        pix_q <= pix_d;
  end

  assign pix_out = pix_q;

  // R3: no scan in a cycle means a transparent pixel after it
  assert_idle_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> pix_out == '0);
  // R6: blanked display shows nothing
  assert_blank_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_en |=> pix_out == '0);
  // R7: blanked left columns show nothing
  assert_left_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && left_blank && rd_x < LEFT_X) |=> pix_out == '0);
endmodule

// File: tb/sim_sprite_linebuf.sv
module sim_sprite_linebuf;
  localparam int PERIOD = 10;

  logic       clk, rst_n, line_start, disp_en, left_blank, wide_mode;
  logic       wr_en, rd_en;
  logic [8:0] wr_x, rd_x;
  logic [5:0] wr_pix, pix_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  sprite_linebuf u0 (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .disp_en(disp_en),
    .left_blank(left_blank), .wide_mode(wide_mode), .wr_en(wr_en),
    .wr_x(wr_x), .wr_pix(wr_pix), .rd_en(rd_en), .rd_x(rd_x),
    .pix_out(pix_out)
  );

  initial clk = 0;
  always #(PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int x, input int p);
    wr_en = 1; wr_x = 9'(x); wr_pix = 6'(p);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd_chk(input string req, input int x, input int exp);
    rd_en = 1; rd_x = 9'(x);
    @(negedge clk);
    rd_en = 0;
    check(req, pix_out, 6'(exp));
  endtask

  task automatic swap();
    line_start = 1;
    @(negedge clk);
    line_start = 0;
  endtask

  task automatic t_reset();
    check("R1 out", pix_out, 0);
    rd_chk("R1 bankB", 0, 0);
    rd_chk("R1 bankB", 100, 0);
    swap();
    rd_chk("R1 bankA", 0, 0);
    rd_chk("R1 bankA", 319, 0);
    swap();
  endtask

  task automatic t_basic();
    // render bank is A again
    for (int i = 0; i < 4; i++) begin
      wr_en = 1; wr_x = 9'(10 + i); wr_pix = 6'(5 + i);
      @(negedge clk);
    end
    wr_en = 0;
    rd_chk("R2 before swap", 10, 0);
    swap();
    for (int i = 0; i < 4; i++) rd_chk("R5 R3 burst", 10 + i, 5 + i);
    @(negedge clk);
    check("R3 idle", pix_out, 0);
    rd_chk("R4 cleared", 11, 0);
  endtask

  task automatic t_disp();
    wr(20, 9);
    swap();
    disp_en = 0;
    rd_chk("R6 blank read", 20, 0);
    wr(30, 3);
    disp_en = 1;
    rd_chk("R6 survived", 20, 9);
    swap();
    rd_chk("R6 write dropped", 30, 0);
    wr(40, 4);
    disp_en = 0;
    swap();
    disp_en = 1;
    rd_chk("R2 swap while blank", 40, 4);
    wr(50, 11);
    swap();
    swap();
    swap();
    rd_chk("R6 stale returns", 50, 11);
  endtask

  task automatic t_left();
    left_blank = 1;
    wr(3, 7);
    wr(8, 12);
    swap();
    rd_chk("R7 left read", 3, 0);
    rd_chk("R7 col8", 8, 12);
    left_blank = 0;
    rd_chk("R7 left write dropped", 3, 0);
    wr(5, 2);
    swap();
    left_blank = 1;
    rd_chk("R7 hidden", 5, 0);
    left_blank = 0;
    rd_chk("R7 kept", 5, 2);
  endtask

  task automatic t_width();
    wide_mode = 0;
    wr(300, 13);
    wr(255, 14);
    wide_mode = 1;
    wr(319, 15);
    wr(400, 16);
    swap();
    rd_chk("R8 narrow drop", 300, 0);
    rd_chk("R8 narrow edge", 255, 14);
    rd_chk("R8 wide edge", 319, 15);
    rd_chk("R8 beyond depth", 400, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    rst_n = 0; line_start = 0; disp_en = 1; left_blank = 0; wide_mode = 1;
    wr_en = 0; rd_en = 0; wr_x = '0; rd_x = '0; wr_pix = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_disp();
    t_left();
    t_width();
    finish_run();
  end

  initial begin
    #(PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule